// File: doc/BRIEF.md
# Flash Power-Mode and Reset Sequencer

This block holds the control state of a parallel NOR-style flash array apart from the array itself. It watches the chip-enable, output-enable and write-enable pins, the active-low hardware reset pin, the address bus and a busy flag from the internal program/erase engine. From these it decides when the data pins may be driven and when read data is valid. It also decides when output data must be held latched because the part has dropped into automatic sleep, and when the ready/busy pin reads busy.

Standby is entered when the part is deselected and not in reset, but only once any embedded operation has finished. Leaving standby costs a full chip-enable access time before data becomes valid. Automatic sleep depends only on how long the address has been stable, never on the control pins. A low pulse on the reset pin only counts once it has lasted the minimum pulse width. A valid pulse returns the command logic to read-array mode and aborts a running operation, and it is followed by an internal reset time. That time is longer when an operation was interrupted. A recovery interval follows the release of the pin. All times are parameters counted in clock cycles.

Top module: `flash_pwr_seq`

## Requirements
- R1: After a clock edge that samples ce_n=1, pin_rst_n=1 and eng_busy=0, in_standby is 1, and out_drive_en and data_valid are 0 whatever oe_n is.
- R2: While eng_busy is sampled 1, in_standby stays 0 even with ce_n high. in_standby becomes 1 at the first edge that samples eng_busy=0 with ce_n high.
- R3: After leaving standby, data_valid rises at the T_CE-th edge after the first edge that samples ce_n=0, with the address held stable.
- R4: An edge that samples an address differing from the previously sampled one clears data_valid. data_valid rises again at the T_ACC-th edge after it.
- R5: data_hold (automatic sleep) rises at the (T_ACC+T_SLP_EXTRA)-th edge after the last edge that saw an address change, whatever ce_n, oe_n and we_n do. It drops after the next edge that sees a new address.
- R6: A reset-pin low pulse that is sampled low on fewer than T_RP consecutive edges produces no read_array_strobe and no abort_pulse. cmd_ignore returns to 0 after the first edge that samples the pin high.
- R7: From the first edge that samples pin_rst_n=0 until reset recovery ends, cmd_ignore is 1 and out_drive_en and data_valid are 0.
- R8: On the T_RP-th consecutive edge that samples the pin low, read_array_strobe is 1 for exactly one cycle. If eng_busy was 1 on that edge, abort_pulse is 1 in the same single cycle; otherwise abort_pulse stays 0.
- R9: When a valid reset aborts an operation, ready_busy_n (1 = ready) stays 0 for exactly T_RDY_EMB cycles after the validating edge, even if the engine drops its busy flag at once.
- R10: When a valid reset finds no operation running, ready_busy_n stays 1 throughout. If the pin is released before the internal reset completes, cmd_ignore falls at the (T_RDY_IDLE+T_RH)-th edge after the validating edge.
- R11: If the pin is still low when the internal reset completes, cmd_ignore falls at the T_RH-th edge after the first edge that samples the pin high.
- R12: Outside reset and standby, out_drive_en is 1 exactly when ce_n=0, oe_n=0 and we_n=1. Outside a reset, ready_busy_n equals the inverse of eng_busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock; all timing parameters count its cycles |
| rst_n | input | 1 | Active-low logic reset of the sequencer |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| pin_rst_n | input | 1 | Hardware reset pin, active low, synchronous to clk |
| addr | input | AW | Address bus |
| eng_busy | input | 1 | Program/erase engine is running |
| out_drive_en | output | 1 | Enable for the data output drivers (0 = high impedance) |
| data_valid | output | 1 | Read data on the outputs is valid |
| data_hold | output | 1 | Automatic sleep: keep last output data latched |
| in_standby | output | 1 | Part is in standby |
| ready_busy_n | output | 1 | Ready/busy pin, 1 = ready |
| cmd_ignore | output | 1 | Read and write commands must be ignored |
| read_array_strobe | output | 1 | One-cycle pulse returning the command logic to read-array mode |
| abort_pulse | output | 1 | One-cycle pulse: a running operation was aborted by reset |

## Verification
The assertions take the reset pin, the control pins and the address to be synchronous to clk and settled before each edge, so that each is sampled once per cycle. They also assume the engine busy flag changes only between edges. The bench drives every input on the falling edge and samples outputs half a cycle later. It drops eng_busy only after it has seen abort_pulse, which is the engine's reaction the busy-time checks assume. Address changes are single writes of a new value on the falling edge, so the stability counters see one clean change per step.

// File: rtl/flash_pwr_pkg.sv
package flash_pwr_pkg;

   typedef enum logic [2:0] {
      RS_IDLE  = 3'd0,
      RS_LOW   = 3'd1,
      RS_WAIT  = 3'd2,
      RS_HELD  = 3'd3,
      RS_RECOV = 3'd4
   } rst_state_t;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int cnt_bits(input int v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/fps_addr_watch.sv
module fps_addr_watch #(
   parameter int AW    = 8,
   parameter int T_ACC = 4,
   parameter int T_SLP = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   output logic          addr_ready_o,
   output logic          sleep_o
);
   import flash_pwr_pkg::*;

   localparam int ACW = cnt_bits(T_ACC);
   localparam int SCW = cnt_bits(T_SLP);

   logic [AW-1:0]  addr_q;
   logic [AW-1:0]  bit_diff;
   logic           chg;
   logic [ACW-1:0] acc_cnt;
   logic [SCW-1:0] slp_cnt;

   for (genvar i = 0; i < AW; i++) begin : g_diff
      assign bit_diff[i] = addr[i] ^ addr_q[i];
   end
   assign chg = |bit_diff;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         acc_cnt <= ACW'(T_ACC);
         slp_cnt <= SCW'(T_SLP);
      end else begin
         addr_q <= addr;
         if (chg)
            acc_cnt <= ACW'(T_ACC);
         else if (acc_cnt != '0)
            acc_cnt <= acc_cnt - 1'b1;
         if (chg)
            slp_cnt <= SCW'(T_SLP);
         else if (slp_cnt != '0)
            slp_cnt <= slp_cnt - 1'b1;
      end
   end

   assign addr_ready_o = (acc_cnt == '0);
   assign sleep_o      = (slp_cnt == '0);

   assert_addr_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> !addr_ready_o);

   assert_sleep_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> !sleep_o);

endmodule

// File: rtl/fps_standby_gate.sv
module fps_standby_gate #(
   parameter int T_CE = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic pin_rst_n,
   input  logic eng_busy,
   output logic stby_o,
   output logic ce_ready_o
);
   import flash_pwr_pkg::*;

   localparam int CCW = cnt_bits(T_CE);

   logic           stby_q;
   logic [CCW-1:0] ce_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stby_q <= 1'b0;
         ce_cnt <= CCW'(T_CE);
      end else begin
         stby_q <= ce_n & pin_rst_n & ~eng_busy;
         if (stby_q)
            ce_cnt <= CCW'(T_CE);
         else if (ce_cnt != '0)
            ce_cnt <= ce_cnt - 1'b1;
      end
   end

   assign stby_o     = stby_q;
   assign ce_ready_o = (ce_cnt == '0);

   assert_busy_keeps_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |=> !stby_o);

   assert_ce_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stby_o) |-> !ce_ready_o);

endmodule

// File: rtl/fps_reset_ctrl.sv
module fps_reset_ctrl #(
   parameter int T_RP       = 3,
   parameter int T_RDY_EMB  = 20,
   parameter int T_RDY_IDLE = 5,
   parameter int T_RH       = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_rst_n,
   input  logic eng_busy,
   output logic rst_idle_o,
   output logic hold_busy_o,
   output logic strobe_o,
   output logic abort_o
);
   import flash_pwr_pkg::*;

   localparam int TMAX = max_of(max_of(T_RP, T_RH), max_of(T_RDY_EMB, T_RDY_IDLE));
   localparam int CW   = cnt_bits(TMAX);

   rst_state_t    state_q;
   logic [CW-1:0] pw_cnt;
   logic [CW-1:0] rdy_cnt;
   logic [CW-1:0] rh_cnt;
   logic          emb_q;
   logic          strobe_q;
   logic          abort_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= RS_IDLE;
         pw_cnt   <= '0;
         rdy_cnt  <= '0;
         rh_cnt   <= '0;
         emb_q    <= 1'b0;
         strobe_q <= 1'b0;
         abort_q  <= 1'b0;
      end else begin
         strobe_q <= 1'b0;
         abort_q  <= 1'b0;
         case (state_q)
            RS_IDLE: begin
               if (!pin_rst_n) begin
                  state_q <= RS_LOW;
                  pw_cnt  <= CW'(1);
               end
            end
            RS_LOW: begin
               if (pin_rst_n) begin
                  state_q <= RS_IDLE;
               end else if (pw_cnt == CW'(T_RP - 1)) begin
                  state_q  <= RS_WAIT;
                  rdy_cnt  <= eng_busy ? CW'(T_RDY_EMB) : CW'(T_RDY_IDLE);
                  emb_q    <= eng_busy;
                  strobe_q <= 1'b1;
                  abort_q  <= eng_busy;
               end else begin
                  pw_cnt <= pw_cnt + 1'b1;
               end
            end
            RS_WAIT: begin
               if (rdy_cnt <= CW'(1)) begin
                  emb_q <= 1'b0;
                  if (pin_rst_n) begin
                     state_q <= RS_RECOV;
                     rh_cnt  <= CW'(T_RH);
                  end else begin
                     state_q <= RS_HELD;
                  end
               end else begin
                  rdy_cnt <= rdy_cnt - 1'b1;
               end
            end
            RS_HELD: begin
               if (pin_rst_n) begin
                  state_q <= RS_RECOV;
                  rh_cnt  <= CW'(T_RH);
               end
            end
            RS_RECOV: begin
               if (!pin_rst_n) begin
                  state_q <= RS_LOW;
                  pw_cnt  <= CW'(1);
               end else if (rh_cnt <= CW'(1)) begin
                  state_q <= RS_IDLE;
               end else begin
                  rh_cnt <= rh_cnt - 1'b1;
               end
            end
            default: state_q <= RS_IDLE;
         endcase
      end
   end

   assign rst_idle_o  = (state_q == RS_IDLE);
   assign hold_busy_o = (state_q == RS_WAIT) & emb_q;
   assign strobe_o    = strobe_q;
   assign abort_o     = abort_q;

   assert_pin_low_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_rst_n |=> !rst_idle_o);

   assert_abort_with_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> strobe_o);

   assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |=> !strobe_o);

   assert_abort_holds_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> hold_busy_o);

   assert_strobe_only_in_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> !rst_idle_o);

endmodule

// File: rtl/flash_pwr_seq.sv
module flash_pwr_seq #(
   parameter int AW          = 8,
   parameter int T_CE        = 6,
   parameter int T_ACC       = 4,
   parameter int T_SLP_EXTRA = 8,
   parameter int T_RP        = 3,
   parameter int T_RDY_EMB   = 20,
   parameter int T_RDY_IDLE  = 5,
   parameter int T_RH        = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic          pin_rst_n,
   input  logic [AW-1:0] addr,
   input  logic          eng_busy,
   output logic          out_drive_en,
   output logic          data_valid,
   output logic          data_hold,
   output logic          in_standby,
   output logic          ready_busy_n,
   output logic          cmd_ignore,
   output logic          read_array_strobe,
   output logic          abort_pulse
);

   localparam int T_SLP = T_ACC + T_SLP_EXTRA;

   if (AW < 1) begin : g_bad_aw
      $error("flash_pwr_seq: AW must be at least 1");
   end
   if (T_RP < 2) begin : g_bad_rp
      $error("flash_pwr_seq: T_RP must be at least 2");
   end
   if (T_RH < 1 || T_RDY_EMB < 1 || T_RDY_IDLE < 1) begin : g_bad_rdy
      $error("flash_pwr_seq: ready and recovery times must be at least 1");
   end
   if (T_CE < 1 || T_ACC < 1) begin : g_bad_acc
      $error("flash_pwr_seq: access times must be at least 1");
   end

   logic addr_ready;
   logic sleep;
   logic stby;
   logic ce_ready;
   logic rst_idle;
   logic hold_busy;

   fps_addr_watch #(
      .AW    (AW),
      .T_ACC (T_ACC),
      .T_SLP (T_SLP)
   ) u_addr (
      .clk          (clk),
      .rst_n        (rst_n),
      .addr         (addr),
      .addr_ready_o (addr_ready),
      .sleep_o      (sleep)
   );

   fps_standby_gate #(
      .T_CE (T_CE)
   ) u_stby (
      .clk        (clk),
      .rst_n      (rst_n),
      .ce_n       (ce_n),
      .pin_rst_n  (pin_rst_n),
      .eng_busy   (eng_busy),
      .stby_o     (stby),
      .ce_ready_o (ce_ready)
   );

   fps_reset_ctrl #(
      .T_RP       (T_RP),
      .T_RDY_EMB  (T_RDY_EMB),
      .T_RDY_IDLE (T_RDY_IDLE),
      .T_RH       (T_RH)
   ) u_rst (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_rst_n   (pin_rst_n),
      .eng_busy    (eng_busy),
      .rst_idle_o  (rst_idle),
      .hold_busy_o (hold_busy),
      .strobe_o    (read_array_strobe),
      .abort_o     (abort_pulse)
   );

   assign out_drive_en = ~ce_n & ~oe_n & we_n & ~stby & rst_idle;
   assign data_valid   = ~stby & ce_ready & addr_ready & rst_idle;
   assign data_hold    = sleep;
   assign in_standby   = stby;
   assign ready_busy_n = ~eng_busy & ~hold_busy;
   assign cmd_ignore   = ~rst_idle;

   assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_standby |-> (!out_drive_en && !data_valid));

   assert_abort_busy_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |-> !ready_busy_n);

endmodule

// File: tb/flash_pwr_seq_tb.sv
`timescale 1ns/1ps
module flash_pwr_seq_tb;

   localparam int AW          = 8;
   localparam int T_CE        = 6;
   localparam int T_ACC       = 4;
   localparam int T_SLP_EXTRA = 8;
   localparam int T_RP        = 3;
   localparam int T_RDY_EMB   = 20;
   localparam int T_RDY_IDLE  = 5;
   localparam int T_RH        = 4;
   localparam int T_SLP       = T_ACC + T_SLP_EXTRA;
   localparam int LIMIT       = 300;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ce_n, oe_n, we_n, pin_rst_n, eng_busy;
   logic [AW-1:0] addr;
   logic          out_drive_en, data_valid, data_hold, in_standby;
   logic          ready_busy_n, cmd_ignore, read_array_strobe, abort_pulse;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   flash_pwr_seq #(
      .AW(AW), .T_CE(T_CE), .T_ACC(T_ACC), .T_SLP_EXTRA(T_SLP_EXTRA),
      .T_RP(T_RP), .T_RDY_EMB(T_RDY_EMB), .T_RDY_IDLE(T_RDY_IDLE), .T_RH(T_RH)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .pin_rst_n(pin_rst_n), .addr(addr), .eng_busy(eng_busy),
      .out_drive_en(out_drive_en), .data_valid(data_valid), .data_hold(data_hold),
      .in_standby(in_standby), .ready_busy_n(ready_busy_n), .cmd_ignore(cmd_ignore),
      .read_array_strobe(read_array_strobe), .abort_pulse(abort_pulse)
   );

   task automatic check(input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
      pin_rst_n = 1'b1; eng_busy = 1'b0; addr = '0;
      repeat (3) step();
      check("R7 reset out_drive_en", out_drive_en, 0);
      check("R8 reset strobe", read_array_strobe, 0);
      check("R8 reset abort", abort_pulse, 0);
      check("R12 reset ready", ready_busy_n, 1);
      check("R6 reset cmd_ignore", cmd_ignore, 0);
      check("R5 reset data_hold", data_hold, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_standby();
      ce_n = 1'b1; oe_n = 1'b0;
      step();
      check("R1 standby entered", in_standby, 1);
      check("R1 standby no drive with oe low", out_drive_en, 0);
      check("R1 standby data_valid", data_valid, 0);
   endtask

   task automatic t_ce_access();
      int m = 0;
      repeat (T_SLP + 2) step();
      ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      step();
      check("R3 valid low at ce edge", data_valid, 0);
      while (!data_valid && m < LIMIT) begin step(); m++; end
      check("R3 ce access edges", m, T_CE);
      check("R12 drive with ce/oe low we high", out_drive_en, 1);
   endtask

   task automatic t_addr_access();
      int m = 0;
      addr = 8'h5A;
      step();
      check("R4 valid cleared on address change", data_valid, 0);
      while (!data_valid && m < LIMIT) begin step(); m++; end
      check("R4 address access edges", m, T_ACC);
   endtask

   task automatic t_sleep();
      int m = 0;
      addr = 8'hC3;
      step();
      check("R5 hold low after change", data_hold, 0);
      while (!data_hold && m < LIMIT) begin
         ce_n = ~ce_n; oe_n = ~oe_n; we_n = ~we_n;
         step(); m++;
      end
      check("R5 sleep entry edges with control toggling", m, T_SLP);
      ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      repeat (3) step();
      check("R5 hold stays while stable", data_hold, 1);
      addr = 8'h3C;
      step();
      check("R5 hold drops on new address", data_hold, 0);
      repeat (T_CE + T_ACC + 2) step();
   endtask

   task automatic t_drive();
      we_n = 1'b0; #1;
      check("R12 no drive while we low", out_drive_en, 0);
      we_n = 1'b1; oe_n = 1'b1; #1;
      check("R12 no drive while oe high", out_drive_en, 0);
      oe_n = 1'b0; #1;
      check("R12 drive restored", out_drive_en, 1);
      check("R12 ready follows engine idle", ready_busy_n, 1);
      step();
   endtask

   task automatic t_busy_deselect();
      eng_busy = 1'b1; ce_n = 1'b1;
      #1 check("R12 ready low while engine busy", ready_busy_n, 0);
      repeat (3) step();
      check("R2 no standby while busy", in_standby, 0);
      eng_busy = 1'b0;
      step();
      check("R2 standby after busy ends", in_standby, 1);
      ce_n = 1'b0;
      repeat (T_CE + 2) step();
   endtask

   task automatic t_short_pulse();
      int strobes = 0;
      pin_rst_n = 1'b0;
      for (int i = 0; i < T_RP - 1; i++) begin
         step();
         strobes += int'(read_array_strobe) + int'(abort_pulse);
      end
      check("R7 cmd_ignore during low", cmd_ignore, 1);
      check("R7 no drive during low", out_drive_en, 0);
      check("R7 no valid during low", data_valid, 0);
      pin_rst_n = 1'b1;
      step();
      strobes += int'(read_array_strobe) + int'(abort_pulse);
      check("R6 short pulse no strobe/abort", strobes, 0);
      check("R6 cmd_ignore cleared", cmd_ignore, 0);
      repeat (2) step();
   endtask

   task automatic t_reset_idle();
      int m = 0;
      int rdy_low = 0;
      int extra = 0;
      pin_rst_n = 1'b0;
      repeat (T_RP - 1) step();
      check("R8 no strobe before width", read_array_strobe, 0);
      step();
      check("R8 strobe at validating edge", read_array_strobe, 1);
      check("R8 no abort when idle", abort_pulse, 0);
      pin_rst_n = 1'b1;
      while (cmd_ignore && m < LIMIT) begin
         step(); m++;
         if (!ready_busy_n) rdy_low++;
         extra += int'(read_array_strobe);
      end
      check("R8 strobe single cycle", extra, 0);
      check("R10 ready stays high", rdy_low, 0);
      check("R10 idle reset plus recovery edges", m, T_RDY_IDLE + T_RH);
      repeat (2) step();
   endtask

   task automatic t_reset_emb();
      int m = 0;
      eng_busy = 1'b1;
      pin_rst_n = 1'b0;
      repeat (T_RP) step();
      check("R8 strobe with abort", read_array_strobe, 1);
      check("R8 abort pulse", abort_pulse, 1);
      check("R9 busy at abort", ready_busy_n, 0);
      eng_busy = 1'b0;
      while (!ready_busy_n && m < LIMIT) begin step(); m++; end
      check("R9 embedded ready time", m, T_RDY_EMB);
      repeat (3) step();
      check("R11 ignore held while pin low", cmd_ignore, 1);
      pin_rst_n = 1'b1;
      step();
      m = 0;
      while (cmd_ignore && m < LIMIT) begin step(); m++; end
      check("R11 recovery edges", m, T_RH);
      check("R12 drive after recovery", out_drive_en, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset_state();
      t_standby();
      t_ce_access();
      t_addr_access();
      t_sleep();
      t_drive();
      t_busy_deselect();
      t_short_pulse();
      t_reset_idle();
      t_reset_emb();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule